// File: doc/BRIEF.md
# Dual-Source Program Counter

This block holds the instruction address of a small byte-wide processor. It has two ways to be loaded. In data-bus mode it takes one 8-bit byte per load, and a high/low select line picks which half of the counter receives the byte. In address-bus mode it takes all 16 bits from the address bus in a single load. A separate strobe advances the counter by one, and an output enable places the counter value on a shared, OR-combined address bus.

The whole-word path exists for subroutine calls. A call must first push the return address, which is the address that follows the call and its operand. It must then move the target address into the counter. The target is already on the address bus at that point, so loading it from there costs one step instead of two byte loads, and the call fits in a tight microstep budget. A return pops two bytes and loads them through the byte path, high byte and low byte separately. The microcode sequencer and the memory sit outside this block.

Top module: `dual_src_pc`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the counter becomes 0x0000, whatever the other inputs are.
- R2: `addr_out` equals the counter value while `addr_oe` is 1, and equals 0x0000 while `addr_oe` is 0; `addr_oe` does not change the stored value.
- R3: `load` with `src_sel`=1 (address source) captures all 16 bits of `addr_bus` at the next edge.
- R4: `load` with `src_sel`=0 (data source) and `byte_hi`=1 writes `data_bus` into bits 15:8 and keeps bits 7:0.
- R5: `load` with `src_sel`=0 and `byte_hi`=0 writes `data_bus` into bits 7:0 and keeps bits 15:8.
- R6: `incr` without `load` adds one to the counter at the next edge.
- R7: Incrementing 0xFFFF gives 0x0000.
- R8: When `load` and `incr` are both 1, the load is performed and the increment is discarded.
- R9: With `load` and `incr` both 0, the counter keeps its value.
- R10: With `src_sel`=1, `byte_hi` has no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| data_bus | input | 8 | Byte source for data-bus loads |
| addr_bus | input | 16 | Word source for address-bus loads |
| byte_hi | input | 1 | Data-bus loads: 1 = upper byte, 0 = lower byte |
| src_sel | input | 1 | 0 = data bus, 1 = address bus |
| load | input | 1 | Load strobe |
| incr | input | 1 | Increment strobe |
| addr_oe | input | 1 | Drive counter value onto address output |
| addr_out | output | 16 | Counter value when enabled, zero otherwise |

## Verification
Load and increment can both be requested in the same cycle. The bench provokes this with all three load flavours: a whole word from the address bus, an upper byte, and a lower byte. In each case it expects only the loaded value, with no extra one added. The scoreboard checks this one edge later, with the output enabled. A second collision is tested too: the output enable is raised in the same cycle as a load, which is how a call drives the return value and takes the target. The bench checks that the newly loaded target is what appears on the next cycle.

// File: rtl/dual_src_pc_pkg.sv
// Package: shared types for the dual-source program counter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dual_src_pc_pkg;

    // Where a load takes its value from.
    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_ADDR = 1'b1
    } pc_src_e;

    // What the counter register does in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_LOAD = 2'd2
    } pc_act_e;

endpackage

// File: rtl/pc_load_mux.sv
// Module: pc_load_mux
// Builds the value a load would write. In data-source mode one byte lane
// is replaced by the data bus and all other lanes keep the current value.
// In address-source mode the whole address bus is taken.
// Assumes ADDR_W is a whole multiple (>= 2) of DATA_W. The high select
// addresses the top lane, and the low select addresses lane zero.
module pc_load_mux
    import dual_src_pc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] cur_val,
    input  logic [DATA_W-1:0] data_bus,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic              byte_hi,
    input  pc_src_e           src,
    output logic [ADDR_W-1:0] load_val
);
    localparam int LANES = ADDR_W / DATA_W;

    logic [ADDR_W-1:0] merged;

    // One lane per byte of the counter; only the selected lane is replaced.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_wr;
        assign lane_wr = byte_hi ? (g == LANES - 1) : (g == 0);
        assign merged[g*DATA_W +: DATA_W] =
            lane_wr ? data_bus : cur_val[g*DATA_W +: DATA_W];
    end

    // Choose between the byte-merged word and the full address bus.
    always_comb begin
        load_val = (src == SRC_ADDR) ? addr_bus : merged;
    end

    // Check: in data mode exactly one lane may change (R4, R5).
    always_comb begin
        if (src == SRC_DATA) begin
            a_one_lane_r5: assert ((load_val[ADDR_W-1:DATA_W] == cur_val[ADDR_W-1:DATA_W])
                                || (load_val[DATA_W-1:0] == cur_val[DATA_W-1:0]));
        end
    end
endmodule

// File: rtl/pc_step_unit.sv
// Module: pc_step_unit
// Adds one to the counter value with plain modulo-2^ADDR_W wrap.
// Assumes the caller decides whether the result is used.
module pc_step_unit #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_val,
    output logic [ADDR_W-1:0] next_val
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Modulo increment; the carry out is dropped on purpose.
    always_comb begin
        next_val = cur_val + ONE;
    end

    // Check: the all-ones value steps to zero (R7).
    always_comb begin
        if (&cur_val) begin
            a_wrap_zero_r7: assert (next_val == '0);
        end
    end
endmodule

// File: rtl/pc_state_reg.sv
// Module: pc_state_reg
// Holds the counter. It decides between hold, increment and load, and load
// wins over increment. Synchronous active-low reset clears it to zero.
// Assumes the candidate load and increment values come from outside.
module pc_state_reg
    import dual_src_pc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              incr,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [ADDR_W-1:0] inc_val,
    output logic [ADDR_W-1:0] pc_q
);
    pc_act_e act;

    // Decode the strobes into one action, with load taking priority.
    always_comb begin
        if (load)      act = ACT_LOAD;
        else if (incr) act = ACT_INC;
        else           act = ACT_HOLD;
    end

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: pc_q <= load_val;
                ACT_INC:  pc_q <= inc_val;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    // R1: reset clears the counter.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0);

    // R9: no strobe, no change.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !incr) |=> $stable(pc_q));

    // R6: increment alone advances by one.
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !load) |=> pc_q == $past(pc_q) + {{(ADDR_W-1){1'b0}}, 1'b1});

    // R8: load present, load value taken regardless of increment.
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pc_q == $past(load_val));
endmodule

// File: rtl/dual_src_pc.sv
// Module: dual_src_pc (top)
// A 16-bit program counter with byte loads from the data bus, word loads
// from the address bus, increment, and a gated drive onto an OR-combined
// address bus. Assumes a single clock and synchronous active-low reset.
module dual_src_pc
    import dual_src_pc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_bus,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic              byte_hi,
    input  logic              src_sel,
    input  logic              load,
    input  logic              incr,
    input  logic              addr_oe,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] inc_val;
    pc_src_e           src;

    // Map the raw select pin onto the source type.
    always_comb begin
        src = src_sel ? SRC_ADDR : SRC_DATA;
    end

    pc_load_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .cur_val  (pc_q),
        .data_bus (data_bus),
        .addr_bus (addr_bus),
        .byte_hi  (byte_hi),
        .src      (src),
        .load_val (load_val)
    );

    pc_step_unit #(.ADDR_W(ADDR_W)) u_step (
        .cur_val  (pc_q),
        .next_val (inc_val)
    );

    pc_state_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .incr     (incr),
        .load_val (load_val),
        .inc_val  (inc_val),
        .pc_q     (pc_q)
    );

    // Drive the shared bus only when enabled; zero keeps the OR bus clean.
    always_comb begin
        addr_out = addr_oe ? pc_q : '0;
    end

    // R3/R10: an address-source load takes the bus word whatever byte_hi is.
    p_word_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && src_sel) |=> pc_q == $past(addr_bus));

    // R4: upper byte load keeps the lower byte.
    p_hi_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !src_sel && byte_hi) |=>
            (pc_q[ADDR_W-1:DATA_W] == $past(data_bus)) &&
            (pc_q[DATA_W-1:0] == $past(pc_q[DATA_W-1:0])));

    // R5: lower byte load keeps the upper bytes.
    p_lo_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !src_sel && !byte_hi) |=>
            (pc_q[DATA_W-1:0] == $past(data_bus)) &&
            (pc_q[ADDR_W-1:DATA_W] == $past(pc_q[ADDR_W-1:DATA_W])));

    // R2: a disabled output contributes nothing to the bus.
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> addr_out == '0);
endmodule

// File: tb/dual_src_pc_test.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module dual_src_pc_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  data_bus;
    logic [15:0] addr_bus;
    logic        byte_hi, src_sel, load, incr, addr_oe;
    logic [15:0] addr_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 16'h0000;
    logic [15:0] exp_q[$];
    string       req_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_src_pc uut (
        .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .addr_bus(addr_bus),
        .byte_hi(byte_hi), .src_sel(src_sel), .load(load), .incr(incr),
        .addr_oe(addr_oe), .addr_out(addr_out)
    );

    // Driver: apply one cycle of inputs at a falling edge and queue the result.
    task automatic step(input logic rst, input logic ld, input logic inc,
                        input logic src, input logic hi, input logic oe,
                        input logic [7:0] d, input logic [15:0] a,
                        input string req);
        rst_n = ~rst; load = ld; incr = inc; src_sel = src;
        byte_hi = hi; addr_oe = oe; data_bus = d; addr_bus = a;
        if (rst)       model = 16'h0000;
        else if (ld)   model = src ? a : (hi ? {d, model[7:0]} : {model[15:8], d});
        else if (inc)  model = model + 16'h0001;
        exp_q.push_back(oe ? model : 16'h0000);
        req_q.push_back(req);
        @(negedge clk);
    endtask

    // Monitor: just after each rising edge, compare against the queue head.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (addr_out !== e) begin
                errors++;
                $display("FAIL %s: addr_out=%h expected=%h", r, addr_out, e);
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load = 0; incr = 0; src_sel = 0; byte_hi = 0;
        addr_oe = 0; data_bus = 0; addr_bus = 0;
        @(negedge clk);
        // R1: reset with loads pending still clears.
        step(1, 1, 1, 1, 0, 1, 8'h55, 16'h9999, "R1");
        // R3: word load.
        step(0, 1, 0, 1, 0, 1, 8'h00, 16'h1234, "R3");
        // R4: upper byte.
        step(0, 1, 0, 0, 1, 1, 8'hAB, 16'hFFFF, "R4");
        // R5: lower byte.
        step(0, 1, 0, 0, 0, 1, 8'hCD, 16'h0000, "R5");
        // R6: increment.
        step(0, 0, 1, 0, 0, 1, 8'h00, 16'h0000, "R6");
        step(0, 0, 1, 1, 1, 1, 8'h77, 16'h7777, "R6");
        // R9: hold with busy buses.
        step(0, 0, 0, 1, 1, 1, 8'hEE, 16'hEEEE, "R9");
        // R2: output disabled reads zero, state kept.
        step(0, 0, 0, 0, 0, 0, 8'h00, 16'h0000, "R2");
        step(0, 0, 0, 0, 0, 1, 8'h00, 16'h0000, "R2");
        // R7: wrap.
        step(0, 1, 0, 1, 0, 1, 8'h00, 16'hFFFF, "R7");
        step(0, 0, 1, 0, 0, 1, 8'h00, 16'h0000, "R7");
        // R8: load and increment together, each load flavour.
        step(0, 1, 1, 1, 0, 1, 8'h00, 16'h4000, "R8");
        step(0, 1, 1, 0, 1, 1, 8'h5A, 16'h0000, "R8");
        step(0, 1, 1, 0, 0, 1, 8'hFF, 16'h0000, "R8");
        // R10: byte_hi ignored on word loads.
        step(0, 1, 0, 1, 1, 1, 8'h11, 16'h0F0E, "R10");
        step(0, 1, 0, 1, 0, 1, 8'h22, 16'hA0B1, "R10");
        // Call: drive and take the target word in the same cycle (R3).
        step(0, 1, 0, 1, 0, 1, 8'h00, 16'h2200, "R3");
        // Return: pop two bytes (R4, R5).
        step(0, 1, 0, 0, 1, 1, 8'h10, 16'h0000, "R4");
        step(0, 1, 0, 0, 0, 1, 8'h03, 16'h0000, "R5");
        // R1: reset mid-run.
        step(1, 0, 1, 0, 0, 1, 8'h00, 16'h0000, "R1");
        step(0, 0, 0, 0, 0, 1, 8'h00, 16'h0000, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule